// File: doc/BRIEF.md
# Addressed Serial Control Word Receiver

This block takes 16-bit control words from a three-wire serial link: a data line, a shift clock and a latch strobe. All three lines are asynchronous to the fast system clock. Each one passes through a synchronizer, and the block looks for edges on the synchronized values. Each rising shift-clock edge pushes one data bit into a shift register. The most significant bit arrives first. The block counts these bits, and the count saturates at sixteen.

A rising edge on the latch strobe closes the frame. The two chip-address bits of the word are compared with two strap pins, so several receivers can share the same three wires. If both bits match, the ten low payload bits go to a parallel output register and a one-cycle update pulse is raised. If either bit differs, the word is dropped and the output register keeps its value. A strobe that comes before sixteen shift edges have arrived is rejected and reported on a one-cycle short-frame output.

Top module: `serialCtrlReg`

## Requirements
- R1: After reset, `payload` is all zeros, `updatePulse` and `shortFrame` are low, and `bitCount` is 0.
- R2: Each rising edge of `serClk` shifts `serData` in, most significant bit first. When more than 16 bits arrive between strobes, only the last 16 form the word: the last bit is D0 and the bit sent 16th from the end is D15.
- R3: On a rising edge of `serLatch` after at least 16 shift edges, if D13 equals `addrStrapHi` and D12 equals `addrStrapLo`, then `payload` takes D9..D0 (D9 is the MSB) and `updatePulse` pulses.
- R4: If either address bit differs from its strap pin, a strobe leaves `payload` unchanged and produces no `updatePulse`.
- R5: Bits D15, D14, D11 and D10 have no effect on acceptance or on `payload`.
- R6: A strobe that comes after fewer than 16 shift edges since the previous strobe (or since reset) leaves `payload` unchanged. It produces no `updatePulse` and raises `shortFrame` for one system clock.
- R7: `bitCount` equals the number of shift edges since the last strobe, saturates at 16, and clears to 0 on every strobe rising edge.
- R8: `updatePulse` is high for exactly one system clock per accepted word. It is never high in the same cycle as `shortFrame`.
- R9: Shift-clock activity alone never changes `payload`. The register changes only on an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serData | input | 1 | Serial data line (asynchronous) |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serLatch | input | 1 | Serial latch strobe (asynchronous) |
| addrStrapHi | input | 1 | Strap pin compared with D13 |
| addrStrapLo | input | 1 | Strap pin compared with D12 |
| payload | output | 10 | Latched payload D9..D0 |
| updatePulse | output | 1 | One-cycle pulse when a word is accepted |
| shortFrame | output | 1 | One-cycle pulse when a strobe is rejected as too short |
| bitCount | output | 5 | Saturating count of shift edges since the last strobe |

## Verification
Overlong frames check that only the last 16 bits count. A design that kept the first bits would load a stale address and payload. Frames of exactly 15 bits and exactly 16 bits sit on either side of the short-frame limit, so an off-by-one in the saturating counter either accepts a partial word or rejects a full one. Words that differ in only one address bit show that a half-match is rejected. Pairs of words that differ only in the ignored bits must give the same result, which exposes a design that decodes those bits. Random frames mix strap settings, frame lengths and data, and after each strobe the bench compares the pulse counts and the payload against its own model.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/serSync.sv
module serSync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/serCtrl.sv
module serCtrl
  import serctl_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkSync,
  input  logic             latchSync,
  output ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] bitCount,
  output logic             shortFrame
);
  logic clkPrev, latchPrev;
  logic clkRise, latchRise, frameFull;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      clkPrev   <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      clkPrev   <= clkSync;
      latchPrev <= latchSync;
    end

  assign clkRise   = clkSync & ~clkPrev;
  assign latchRise = latchSync & ~latchPrev;
  assign frameFull = (bitCount == CNT_W'(WORD_W));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                       bitCount <= '0;
    else if (latchRise)              bitCount <= '0;
    else if (clkRise && !frameFull)  bitCount <= bitCount + 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) shortFrame <= 1'b0;
    else       shortFrame <= latchRise && !frameFull;

  always_comb begin
    strobes.shiftEn = clkRise;
    strobes.loadEn  = latchRise && frameFull;
  end
endmodule

// File: rtl/serDatapath.sv
module serDatapath
  import serctl_pkg::*;
#(
  parameter int PAY_W   = 10,
  parameter int ADDR_HI = 13,
  localparam int KEEP_W = ADDR_HI + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataSync,
  input  ctrlStrobes_t     strobes,
  input  logic             strapHi,
  input  logic             strapLo,
  output logic [PAY_W-1:0] payload,
  output logic             updatePulse
);
  logic [KEEP_W-1:0] shiftReg;
  logic addrMatch;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[KEEP_W-2:0], dataSync};

  assign addrMatch = (shiftReg[ADDR_HI] == strapHi) && (shiftReg[ADDR_HI-1] == strapLo);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      payload     <= '0;
      updatePulse <= 1'b0;
    end else begin
      updatePulse <= strobes.loadEn && addrMatch;
      if (strobes.loadEn && addrMatch) payload <= shiftReg[PAY_W-1:0];
    end
endmodule

// File: rtl/serialCtrlReg.sv
module serialCtrlReg
  import serctl_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int PAY_W   = 10,
  parameter int ADDR_HI = 13,
  parameter int STAGES  = 2,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serData,
  input  logic             serClk,
  input  logic             serLatch,
  input  logic             addrStrapHi,
  input  logic             addrStrapLo,
  output logic [PAY_W-1:0] payload,
  output logic             updatePulse,
  output logic             shortFrame,
  output logic [CNT_W-1:0] bitCount
);
  logic [2:0] syncLines;
  ctrlStrobes_t strobes;

  serSync #(.WIDTH(3), .STAGES(STAGES)) i_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({serLatch, serClk, serData}),
    .syncOut(syncLines)
  );

  serCtrl #(.WORD_W(WORD_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .clkSync(syncLines[1]), .latchSync(syncLines[2]),
    .strobes(strobes), .bitCount(bitCount), .shortFrame(shortFrame)
  );

  serDatapath #(.PAY_W(PAY_W), .ADDR_HI(ADDR_HI)) i_dp (
    .clk(clk), .rstN(rstN),
    .dataSync(syncLines[0]), .strobes(strobes),
    .strapHi(addrStrapHi), .strapLo(addrStrapLo),
    .payload(payload), .updatePulse(updatePulse)
  );
endmodule

// File: rtl/serialCtrlReg_chk.sv
module serialCtrlReg_chk #(
  parameter int WORD_W = 16,
  parameter int PAY_W  = 10,
  parameter int CNT_W  = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [PAY_W-1:0] payload,
  input logic             updatePulse,
  input logic             shortFrame,
  input logic [CNT_W-1:0] bitCount
);
  logic armed;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;

  assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |=> !updatePulse);

  assert_no_pulse_overlap_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(updatePulse && shortFrame));

  assert_payload_only_on_update_R9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !updatePulse) |-> $stable(payload));

  assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(WORD_W));

  assert_count_saturates_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && bitCount == CNT_W'(WORD_W)) |=> (bitCount == CNT_W'(WORD_W) || bitCount == '0));

  assert_short_clears_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && shortFrame) |-> bitCount == '0);
endmodule

bind serialCtrlReg serialCtrlReg_chk #(.WORD_W(WORD_W), .PAY_W(PAY_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .payload(payload), .updatePulse(updatePulse),
  .shortFrame(shortFrame), .bitCount(bitCount)
);

// File: tb/test_serialCtrlReg.sv
module test_serialCtrlReg;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic serData = 1'b0, serClk = 1'b0, serLatch = 1'b0;
  logic addrStrapHi = 1'b0, addrStrapLo = 1'b0;
  logic [9:0] payload;
  logic updatePulse, shortFrame;
  logic [4:0] bitCount;

  int checks = 0, fails = 0;
  int pulseCnt = 0, shortCnt = 0;
  logic prevPulse = 1'b0;
  logic [9:0] expPayload = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serialCtrlReg i_serialCtrlReg (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk), .serLatch(serLatch),
    .addrStrapHi(addrStrapHi), .addrStrapLo(addrStrapLo),
    .payload(payload), .updatePulse(updatePulse), .shortFrame(shortFrame), .bitCount(bitCount)
  );

  always @(posedge clk) begin
    if (rstN) begin
      if (updatePulse) pulseCnt++;
      if (shortFrame) shortCnt++;
      if (updatePulse && prevPulse) begin
        checks++; fails++;
        $display("FAIL R8: update pulse wider than one cycle, actual 2 expected 1");
      end
      if (updatePulse && shortFrame) begin
        checks++; fails++;
        $display("FAIL R8: update and short-frame together, actual 1 expected 0");
      end
    end
    prevPulse <= updatePulse;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // sends bits[n-1] first down to bits[0]
  task automatic sendBits(logic [31:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = bits[i];
      idle(HOLD);
      serClk = 1'b1;
      idle(HOLD);
      serClk = 1'b0;
    end
    idle(HOLD + 2);
  endtask

  task automatic strobe();
    serLatch = 1'b1;
    idle(HOLD + 2);
    serLatch = 1'b0;
    idle(HOLD + 2);
  endtask

  function automatic logic wordAccepted(logic [15:0] w, logic hi, logic lo);
    return (w[13] == hi) && (w[12] == lo);
  endfunction

  // full frame with model-based checks
  task automatic frame(string req, logic [31:0] bits, int n);
    int p0, s0;
    logic [15:0] w;
    w = bits[15:0];
    check(req, payload, expPayload);                 // R9: shifting left it alone
    check("R7", bitCount, (n >= 16) ? 16 : n);
    p0 = pulseCnt; s0 = shortCnt;
    strobe();
    if (n >= 16 && wordAccepted(w, addrStrapHi, addrStrapLo)) begin
      expPayload = w[9:0];
      check(req, pulseCnt - p0, 1);
      check(req, shortCnt - s0, 0);
    end else if (n >= 16) begin
      check(req, pulseCnt - p0, 0);
      check(req, shortCnt - s0, 0);
    end else begin
      check("R6", pulseCnt - p0, 0);
      check("R6", shortCnt - s0, 1);
    end
    check(req, payload, expPayload);
    check("R7", bitCount, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    void'($urandom(32'd4711));
    idle(3);
    // R1 reset state
    check("R1", payload, 0);
    check("R1", updatePulse, 0);
    check("R1", shortFrame, 0);
    check("R1", bitCount, 0);
    rstN = 1'b1;
    idle(4);
    check("R1", payload, 0);

    // R3 matching word with straps 0,0
    sendBits(32'h0000_0155, 16);
    frame("R3", 32'h0000_0155, 16);
    // R4 D12 mismatch only
    sendBits(32'h0000_12AA, 16);
    frame("R4", 32'h0000_12AA, 16);
    // R4 D13 mismatch only
    sendBits(32'h0000_2333, 16);
    frame("R4", 32'h0000_2333, 16);
    // R5 ignored bits set, address 1,0
    addrStrapHi = 1'b1; addrStrapLo = 1'b0;
    sendBits(32'h0000_EE77, 16);
    frame("R5", 32'h0000_EE77, 16);
    check("R5", payload, 10'h277);
    sendBits(32'h0000_2277, 16);
    frame("R5", 32'h0000_2277, 16);
    check("R5", payload, 10'h277);
    // R2 overflow: 20 bits, leading junk has wrong address
    addrStrapHi = 1'b1; addrStrapLo = 1'b1;
    sendBits(32'h000C_31C5, 20);
    frame("R2", 32'h000C_31C5, 20);
    check("R2", payload, 10'h1C5);
    // R6 15 bits short, then 16 exactly
    sendBits(32'h0000_3001, 15);
    frame("R6", 32'h0000_3001, 15);
    sendBits(32'h0000_3002, 16);
    frame("R6", 32'h0000_3002, 16);
    check("R6", payload, 10'h002);
    // R6 strobe with zero bits
    frame("R6", 32'h0, 0);

    // random frames
    for (int k = 0; k < 80; k++) begin
      addrStrapHi = $urandom_range(0, 1);
      addrStrapLo = $urandom_range(0, 1);
      r = $urandom;
      n = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 15) : $urandom_range(16, 24);
      if ($urandom_range(0, 2) != 0) begin
        r[13] = addrStrapHi;
        r[12] = addrStrapLo;
      end
      if (n < 32) r = r & ((32'd1 << n) - 1);
      sendBits(r, n);
      frame("R3", r, n);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule